// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The block gathers sixteen interrupt request lines and turns each rising edge into a pending flag. Among the pending sources that are enabled, it selects one and presents it to the processor as a single interrupt line together with the 4-bit index of that source. Each source has a programmable priority from 0 to 15. Priority 0 keeps a source from interrupting, but its requests are still recorded. When two enabled sources carry the same priority, the higher index wins. While a source is being served, only a source with a strictly higher priority can take over the interrupt line. Service ends when software writes any value to the return register.

Software reaches the block through a byte-wide register port with a 4-bit address. Addresses 0 to 7 hold the priority fields, packed two to a byte. Addresses 8 and 9 expose the pending flags. Address 10 holds two mode bits, and address 11 is the return register. With the mode bits, software can let the controller run freely, stop it once the current service ends, or let exactly one more request through before it stops.

The service state machine has three states. ST_IDLE means nothing is in service. ST_SERVE means a source is being served and the interrupt line is high. ST_HALT means the controller is stopped by the mode bits. The transitions are as follows:
- ACCEPT (ST_IDLE to ST_SERVE) when acceptance is allowed and an enabled source is pending.
- PREEMPT (ST_SERVE to ST_SERVE) when acceptance is allowed and a pending source has a higher priority than the one in service.
- RETURN (ST_SERVE to ST_IDLE) on a return write while acceptance is still allowed.
- STOP_AT_RETURN (ST_SERVE to ST_HALT) on a return write once acceptance is no longer allowed.
- STOP_IDLE (ST_IDLE to ST_HALT) when the mode bits forbid acceptance and nothing is in service.
- RESUME (ST_HALT to ST_IDLE) when a mode write allows acceptance again.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all priority fields and both mode bits are 0 and no flag is pending. `irq_out` is low and every register address reads 0.
- R2: Priority register k (address k, from 0 to 7) holds the priority of input 2k in bits 3:0 and the priority of input 2k+1 in bits 7:4. A write updates both fields and a read returns them.
- R3: A rising edge on `irq_req[i]` sets pending flag i whatever the priority of input i, including 0.
  - Address 8 reads the flags of inputs 0 to 7, with bit i for input i. Address 9 reads the flags of inputs 8 to 15, with bit i-8 for input i.
  - A pending source with priority 0 never raises `irq_out`.
  - Writes to addresses 8 and 9 have no effect.
- R4: Suppose the controller is idle and input i has a nonzero priority. If `irq_req[i]` rises before clock edge 1, `irq_out` is low after edge 3 and high after edge 4. At that point `irq_src` equals i and pending flag i reads 0.
- R5: When several enabled sources are pending at once, the one with the highest priority is accepted first. Among equal priorities, the higher index wins.
- R6: During service, a pending source with a strictly higher priority replaces `irq_src` and keeps `irq_out` high. A pending source with an equal or lower priority waits.
- R7: Any write to address 11 during service, whatever the data, drops `irq_out` after that clock edge. A source still eligible is then accepted one clock later.
- R8: Address 10 holds the mode bits, with bit 0 for stop and bit 1 for one-shot.
  - stop=0 gives normal operation, whatever the one-shot bit.
  - stop=1 with one-shot=0 accepts nothing new, not even a higher priority. The current service runs until its return, and then nothing more is accepted.
  - stop=1 with one-shot=1 accepts exactly one more request after the mode write.
  - Writing stop=0 resumes normal acceptance.
- R9: `reg_rdata` is 0 whenever `reg_rd` is low. Address 10 reads the mode bits back in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 16 | Asynchronous interrupt request lines, active on rising edge |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, combinational from the address while `reg_rd` is high |
| irq_out | output | 1 | Interrupt line to the processor |
| irq_src | output | 4 | Index of the source in service |

## Verification
A wrong winner, or a wrong in-service level, shows on `irq_src` in the cycle a source is accepted or preempted. It also shows on the pending readback, where the flag of a source that should still be waiting has already been cleared. A state machine stuck in the wrong state shows within one clock of a return write or a mode write: `irq_out` stays high when it should drop, or it rises while the mode bits forbid acceptance. A fault in edge latching shows three clocks after a request edge as a missing bit at address 8 or 9.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SERVE = 2'd1,
        ST_HALT  = 2'd2
    } svc_state_e;

    localparam int MODE_STOP_BIT = 0;
    localparam int MODE_ONE_BIT  = 1;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_async,
    output logic [N-1:0] req_rise
);
    logic [N-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= req_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign req_rise = sync_q & ~prev_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int N  = 16,
    parameter int PW = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]    pend,
    input  logic [N*PW-1:0] prio_flat,
    output logic            win_valid,
    output logic [IW-1:0]   win_idx,
    output logic [PW-1:0]   win_prio
);
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = 0; i < N; i++) begin
            if (pend[i] && (prio_flat[i*PW +: PW] != '0) &&
                (prio_flat[i*PW +: PW] >= win_prio)) begin
                win_valid = 1'b1;
                win_idx   = IW'(i);
                win_prio  = prio_flat[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/irq_serve_fsm.sv
module irq_serve_fsm
    import prio_irq_pkg::*;
#(
    parameter int PW = 4,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cand_valid,
    input  logic [IW-1:0] cand_idx,
    input  logic [PW-1:0] cand_prio,
    input  logic          mode_stop,
    input  logic          mode_one,
    input  logic          mode_wr,
    input  logic          ret_wr,
    output logic          accept,
    output logic          irq_out,
    output logic [IW-1:0] irq_src,
    output logic [PW-1:0] svc_level
);
    svc_state_e state, nxt;
    logic       shot_used;
    logic       gate;

    assign gate = !mode_stop || (mode_one && !shot_used);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            irq_src   <= '0;
            svc_level <= '0;
            shot_used <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) begin
                irq_src   <= cand_idx;
                svc_level <= cand_prio;
            end else if (ret_wr && state == ST_SERVE) begin
                svc_level <= '0;
            end
            if (mode_wr)
                shot_used <= 1'b0;
            else if (accept && mode_stop)
                shot_used <= 1'b1;
        end
    end

    always_comb begin
        nxt    = state;
        accept = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (mode_stop && !gate) begin
                    nxt = ST_HALT;
                end else if (gate && cand_valid) begin
                    accept = 1'b1;
                    nxt    = ST_SERVE;
                end
            end
            ST_SERVE: begin
                if (ret_wr)
                    nxt = gate ? ST_IDLE : ST_HALT;
                else if (gate && cand_valid && (cand_prio > svc_level))
                    accept = 1'b1;
            end
            ST_HALT: begin
                if (gate)
                    nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign irq_out = (state == ST_SERVE);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int N_SRC = 16,
    parameter int PW    = 4,
    parameter int DW    = 8,
    parameter int AW    = 4,
    localparam int IW   = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_req,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    input  logic             reg_wr,
    input  logic             reg_rd,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq_out,
    output logic [IW-1:0]    irq_src
);
    localparam int FPR         = DW / PW;
    localparam int N_PRIO_REGS = N_SRC / FPR;
    localparam int N_PEND_REGS = N_SRC / DW;
    localparam int ADDR_PEND0  = N_PRIO_REGS;
    localparam int ADDR_MODE   = ADDR_PEND0 + N_PEND_REGS;
    localparam int ADDR_RET    = ADDR_MODE + 1;

    logic [PW-1:0]       prio_q [N_SRC];
    logic [N_SRC*PW-1:0] prio_flat;
    logic [N_SRC-1:0]    pend_q, req_rise, clr_mask;
    logic [1:0]          mode_q;
    logic                mode_wr, ret_wr, accept;
    logic                cand_valid;
    logic [IW-1:0]       cand_idx;
    logic [PW-1:0]       cand_prio, svc_level;

    assign mode_wr = reg_wr && (reg_addr == AW'(ADDR_MODE));
    assign ret_wr  = reg_wr && (reg_addr == AW'(ADDR_RET));

    for (genvar g = 0; g < N_SRC; g++) begin : g_prio
        assign prio_flat[g*PW +: PW] = prio_q[g];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                prio_q[g] <= '0;
            else if (reg_wr && reg_addr == AW'(g / FPR))
                prio_q[g] <= reg_wdata[(g % FPR)*PW +: PW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= '0;
        else if (mode_wr)
            mode_q <= reg_wdata[1:0];
    end

    irq_sync_edge #(.N(N_SRC)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_async (irq_req),
        .req_rise  (req_rise)
    );

    assign clr_mask = accept ? (N_SRC'(1) << cand_idx) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~clr_mask) | req_rise;
    end

    irq_arbiter #(.N(N_SRC), .PW(PW)) u_arb (
        .pend      (pend_q),
        .prio_flat (prio_flat),
        .win_valid (cand_valid),
        .win_idx   (cand_idx),
        .win_prio  (cand_prio)
    );

    irq_serve_fsm #(.PW(PW), .IW(IW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand_valid (cand_valid),
        .cand_idx   (cand_idx),
        .cand_prio  (cand_prio),
        .mode_stop  (mode_q[MODE_STOP_BIT]),
        .mode_one   (mode_q[MODE_ONE_BIT]),
        .mode_wr    (mode_wr),
        .ret_wr     (ret_wr),
        .accept     (accept),
        .irq_out    (irq_out),
        .irq_src    (irq_src),
        .svc_level  (svc_level)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            for (int j = 0; j < N_PRIO_REGS; j++)
                if (reg_addr == AW'(j))
                    for (int f = 0; f < FPR; f++)
                        reg_rdata[f*PW +: PW] = prio_q[j*FPR + f];
            for (int k = 0; k < N_PEND_REGS; k++)
                if (reg_addr == AW'(ADDR_PEND0 + k))
                    reg_rdata = pend_q[k*DW +: DW];
            if (reg_addr == AW'(ADDR_MODE))
                reg_rdata[1:0] = mode_q;
        end
    end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int AW       = 4,
    parameter int DW       = 8,
    parameter int PW       = 4,
    parameter int IW       = 4,
    parameter int RET_ADDR = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_out,
    input logic [IW-1:0] irq_src,
    input logic [PW-1:0] svc_level,
    input logic [1:0]    mode_q,
    input logic [AW-1:0] reg_addr,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [DW-1:0] reg_rdata
);
    AST_RET_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && reg_wr && reg_addr == AW'(RET_ADDR)) |=> !irq_out); // R7

    AST_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (svc_level != '0)); // R4

    AST_PREEMPT_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && $past(irq_out) && irq_src != $past(irq_src))
        |-> (svc_level > $past(svc_level))); // R6

    AST_STOP_NO_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> (!$past(mode_q[0]) || $past(mode_q[1]))); // R8

    AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> (reg_rdata == '0)); // R9
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
    .AW(AW), .DW(DW), .PW(PW), .IW(IW), .RET_ADDR(ADDR_RET)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_out   (irq_out),
    .irq_src   (irq_src),
    .svc_level (svc_level),
    .mode_q    (mode_q),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_PEND_LO = 4'd8;
    localparam logic [3:0] A_PEND_HI = 4'd9;
    localparam logic [3:0] A_MODE    = 4'd10;
    localparam logic [3:0] A_RET     = 4'd11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_req = '0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_rdata;
    logic        irq_out;
    logic [3:0]  irq_src;

    int errors = 0;
    int checks = 0;
    logic [3:0]  bp [16];
    logic [15:0] model_pend;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .irq_out(irq_out), .irq_src(irq_src)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic set_prio(input int i, input logic [3:0] p);
        logic [7:0] b;
        bp[i] = p;
        b = {bp[(i/2)*2+1], bp[(i/2)*2]};
        wr(4'(i/2), b);
    endtask

    task automatic pulse(input int i);
        @(negedge clk);
        irq_req[i] = 1'b1;
        repeat (4) @(negedge clk);
        irq_req[i] = 1'b0;
    endtask

    task automatic wait_irq(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            if (irq_out) break;
        end
    endtask

    function automatic int winner(input logic [15:0] p);
        int best = -1;
        logic [3:0] bpr = 0;
        for (int i = 0; i < 16; i++)
            if (p[i] && bp[i] != 0 && bp[i] >= bpr) begin
                best = i; bpr = bp[i];
            end
        return best;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
        summary();
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < 16; i++) bp[i] = 0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(irq_out == 1'b0, "R1 irq_out", irq_out, 0);
        for (int a = 0; a < 12; a++) begin
            rd(4'(a), d);
            chk(d == 8'h00, "R1 reg reset", d, 0);
        end

        // R9 read strobe low gives zero; mode readback
        wr(A_MODE, 8'h03);
        @(negedge clk); reg_addr = A_MODE; reg_rd = 1'b0; #1;
        chk(reg_rdata == 8'h00, "R9 no strobe", reg_rdata, 0);
        rd(A_MODE, d);
        chk(d == 8'h03, "R9 mode readback", d, 3);
        wr(A_MODE, 8'h00);

        // R2 priority field packing
        wr(4'd7, 8'hA5);
        rd(4'd7, d);
        chk(d == 8'hA5, "R2 readback", d, 8'hA5);
        wr(4'd7, 8'h00);
        set_prio(1, 4'h6); set_prio(0, 4'h2);
        rd(4'd0, d);
        chk(d == 8'h62, "R2 odd high even low", d, 8'h62);
        set_prio(0, 4'h0); set_prio(1, 4'h0);

        // R3 priority-0 request still latched, never triggers
        pulse(3);
        repeat (4) @(negedge clk);
        chk(irq_out == 1'b0, "R3 prio0 no irq", irq_out, 0);
        rd(A_PEND_LO, d);
        chk(d == 8'h08, "R3 pending bit3", d, 8'h08);
        wr(A_PEND_LO, 8'h00);
        rd(A_PEND_LO, d);
        chk(d == 8'h08, "R3 pending write ignored", d, 8'h08);
        set_prio(3, 4'h1);
        wait_irq(4);
        chk(irq_out && irq_src == 4'd3, "R3 enabled later", irq_src, 3);
        wr(A_RET, 8'h5A);
        chk(irq_out == 1'b0, "R7 return drops", irq_out, 0);
        set_prio(3, 4'h0);

        // R4 exact latency
        set_prio(6, 4'h4);
        @(negedge clk); irq_req[6] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(irq_out == 1'b0, "R4 low after edge3", irq_out, 0);
        @(negedge clk);
        chk(irq_out == 1'b1, "R4 high after edge4", irq_out, 1);
        chk(irq_src == 4'd6, "R4 src", irq_src, 6);
        irq_req[6] = 1'b0;
        rd(A_PEND_LO, d);
        chk(d == 8'h00, "R4 pending cleared", d, 0);
        wr(A_RET, 8'h00);
        set_prio(6, 4'h0);

        // R6 preemption, R7 follow-on acceptance
        set_prio(2, 4'h3); set_prio(5, 4'h3); set_prio(9, 4'h7);
        pulse(5);
        chk(irq_out && irq_src == 4'd5, "R6 first", irq_src, 5);
        pulse(2);
        repeat (2) @(negedge clk);
        chk(irq_out && irq_src == 4'd5, "R6 equal waits", irq_src, 5);
        pulse(9);
        chk(irq_out && irq_src == 4'd9, "R6 higher preempts", irq_src, 9);
        wr(A_RET, 8'hFF);
        chk(irq_out == 1'b0, "R7 drop", irq_out, 0);
        @(negedge clk);
        chk(irq_out && irq_src == 4'd2, "R7 next one cycle later", irq_src, 2);
        wr(A_RET, 8'h00);

        // R8 modes
        set_prio(12, 4'h9);
        pulse(5);
        chk(irq_out && irq_src == 4'd5, "R8 serve", irq_src, 5);
        wr(A_MODE, 8'h01);
        pulse(9);
        repeat (2) @(negedge clk);
        chk(irq_out && irq_src == 4'd5, "R8 stop no preempt", irq_src, 5);
        wr(A_RET, 8'h00);
        repeat (5) @(negedge clk);
        chk(irq_out == 1'b0, "R8 stopped after return", irq_out, 0);
        rd(A_PEND_HI, d);
        chk(d == 8'h02, "R3 pending hi bit9", d, 8'h02);
        wr(A_MODE, 8'h03);
        wait_irq(6);
        chk(irq_out && irq_src == 4'd9, "R8 one-shot", irq_src, 9);
        pulse(12);
        repeat (2) @(negedge clk);
        chk(irq_out && irq_src == 4'd9, "R8 one-shot no preempt", irq_src, 9);
        wr(A_RET, 8'h00);
        repeat (5) @(negedge clk);
        chk(irq_out == 1'b0, "R8 one-shot spent", irq_out, 0);
        wr(A_MODE, 8'h00);
        wait_irq(6);
        chk(irq_out && irq_src == 4'd12, "R8 resume", irq_src, 12);
        wr(A_RET, 8'h00);
        repeat (3) @(negedge clk);

        // R5 random rounds
        model_pend = '0;
        for (int r = 0; r < 40; r++) begin
            logic [15:0] m;
            int w, ri;
            wr(A_MODE, 8'h01);
            for (int k = 0; k < 8; k++) begin
                logic [7:0] b;
                b = 8'($urandom);
                if ((r % 4) == 0) b = (b & 8'h0F) | {b[3:0], 4'h0};
                bp[2*k] = b[3:0]; bp[2*k+1] = b[7:4];
                wr(4'(k), b);
            end
            ri = int'($urandom % 8);
            rd(4'(ri), d);
            chk(d == {bp[2*ri+1], bp[2*ri]}, "R2 random readback", d, {bp[2*ri+1], bp[2*ri]});
            m = 16'($urandom);
            @(negedge clk); irq_req = m;
            repeat (4) @(negedge clk);
            irq_req = '0;
            repeat (2) @(negedge clk);
            model_pend = model_pend | m;
            rd(A_PEND_LO, d);
            chk(d == model_pend[7:0], "R3 random pend lo", d, model_pend[7:0]);
            rd(A_PEND_HI, d);
            chk(d == model_pend[15:8], "R3 random pend hi", d, model_pend[15:8]);
            wr(A_MODE, 8'h00);
            for (int s = 0; s < 17; s++) begin
                w = winner(model_pend);
                if (w < 0) begin
                    repeat (6) @(negedge clk);
                    chk(irq_out == 1'b0, "R3 only prio0 left", irq_out, 0);
                    break;
                end
                wait_irq(8);
                chk(irq_out && irq_src == 4'(w), "R5 winner", irq_src, w);
                model_pend[w] = 1'b0;
                wr(A_RET, 8'(s));
                chk(irq_out == 1'b0, "R7 random return", irq_out, 0);
            end
        end
        summary();
    end
endmodule